// File: doc/BRIEF.md
# Two-Phase Latch Modulo-5 Counter

This block counts from 0 to 4 and then returns to 0, so it divides its count-enable stream by five. Its state is held in toggle cells. Each toggle cell is a pair of transparent latches. The first latch is open while phase clock `phi1` is high. The second latch is open while phase clock `phi2` is high. The two phases never overlap. A cell inverts its bit through XOR feedback when its toggle enable is high, and it holds its bit otherwise. Every cell also has an active-low clear that forces its bit to 0.

Three cells are joined with a ripple-enable chain. Bit 0 toggles whenever counting is enabled. Each higher bit toggles only when counting is enabled and every lower bit is 1. The cell clears are shared and driven low in two cases: when the external clear is high, or when counting is enabled and the count is at its top value of 4. The count therefore wraps to 0 through a forced clear, not through natural binary rollover. The clock source is outside the block, and so is any decoding of the count.

Top module: `mod5_phase_counter`

## Requirements
- R1: When `ce` is high and `clr` is low, bit 0 of `count` inverts on every phase cycle in which the count is below 4. A phase cycle is one `phi1` pulse followed by one `phi2` pulse.
- R2: When `ce` is high, `clr` is low and `count` is below 4, `count` increases by exactly one per phase cycle.
- R3: When `ce` is high, `clr` is low and `count` equals 4, `count` becomes 0 after that phase cycle.
- R4: When `ce` and `clr` are both low, `count` keeps its value across any number of phase cycles.
- R5: When `clr` is high during a phase cycle, `count` is 0 after it, whatever the value of `ce` and whatever the previous count.
- R6: `count` changes only while `phi2` is high. Throughout a `phi1` pulse it keeps the value it had before the cycle began.
- R7: After the first clear, `count` never holds a value above 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi1 | input | 1 | First phase clock; the next-state latches are open while it is high |
| phi2 | input | 1 | Second phase clock, never high together with `phi1`; the output latches are open while it is high |
| ce | input | 1 | Active-high count enable |
| clr | input | 1 | Active-high external clear |
| count | output | 3 | Current count, 0 to 4 in binary |

## Verification
The bench runs the count enable through more than two full laps of the sequence. This separates a correct increment from a counter that skips a value, stops at 3, or rolls on to 5 instead of clearing at 4. It then parks the counter at each of the five values with both controls low, which shows whether a latch leaks a toggle when enable is off. Next it clears from every value, once with enable high and once with enable low. A clear that loses to the wrap term, or that depends on the state, shows up in one of those cases. Inside every `phi1` pulse the bench also samples the output, which catches a second latch that is open on the wrong phase.

// File: rtl/mod5_pkg.sv
package mod5_pkg;
    localparam int CNT_W_DEF   = 3;
    localparam int TOP_VAL_DEF = 4;

    // per-cell control pair produced by the shared control logic
    typedef struct packed {
        logic te;
        logic clr_n;
    } cell_ctl_t;
endpackage

// File: rtl/mod5_toggle_cell.sv
module mod5_toggle_cell (
    input  logic phi1,
    input  logic phi2,
    input  logic te,
    input  logic clr_n,
    output logic q
);
    logic master_d, master_q;
    logic slave_q;

    // next value: XOR toggle, overridden by the active-low clear
    always_comb begin
        master_d = clr_n ? (slave_q ^ te) : 1'b0;
    end

    // first latch, open during phi1
    always_latch begin
        if (phi1) master_q <= master_d;
    end

    // second latch, open during phi2
    always_latch begin
        if (phi2) slave_q <= master_q;
    end

    assign q = slave_q;
endmodule

// File: rtl/mod5_enable_chain.sv
module mod5_enable_chain #(
    parameter int CNT_W = 3
) (
    input  logic             ce,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] te
);
    assign te[0] = ce;

    generate
        for (genvar i = 1; i < CNT_W; i++) begin : g_chain
            assign te[i] = te[i-1] & count[i-1];
        end
    endgenerate
endmodule

// File: rtl/mod5_wrap_ctrl.sv
module mod5_wrap_ctrl #(
    parameter int CNT_W   = 3,
    parameter int TOP_VAL = 4
) (
    input  logic             ce,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    output logic             clr_n
);
    localparam logic [CNT_W-1:0] TOP_CODE = CNT_W'(TOP_VAL);

    logic at_top;

    always_comb begin
        at_top = (count == TOP_CODE);
        clr_n  = ~(clr | (ce & at_top));
    end
endmodule

// File: rtl/mod5_phase_counter.sv
module mod5_phase_counter
    import mod5_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int TOP_VAL = TOP_VAL_DEF
) (
    input  logic             phi1,
    input  logic             phi2,
    input  logic             ce,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] te_vec;
    logic             shared_clr_n;
    cell_ctl_t        ctl [CNT_W];

    mod5_enable_chain #(.CNT_W(CNT_W)) u_chain (
        .ce    (ce),
        .count (count),
        .te    (te_vec)
    );

    mod5_wrap_ctrl #(.CNT_W(CNT_W), .TOP_VAL(TOP_VAL)) u_wrap (
        .ce    (ce),
        .clr   (clr),
        .count (count),
        .clr_n (shared_clr_n)
    );

    generate
        for (genvar i = 0; i < CNT_W; i++) begin : g_bit
            assign ctl[i].te    = te_vec[i];
            assign ctl[i].clr_n = shared_clr_n;

            mod5_toggle_cell u_cell (
                .phi1  (phi1),
                .phi2  (phi2),
                .te    (ctl[i].te),
                .clr_n (ctl[i].clr_n),
                .q     (count[i])
            );
        end
    endgenerate
endmodule

// File: rtl/mod5_phase_chk.sv
module mod5_phase_chk #(
    parameter int CNT_W   = 3,
    parameter int TOP_VAL = 4
) (
    input logic             phi1,
    input logic             phi2,
    input logic             ce,
    input logic             clr,
    input logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP_CODE = CNT_W'(TOP_VAL);

    logic armed_q = 1'b0;

    always_ff @(posedge phi1) begin
        if (clr) armed_q <= 1'b1;
    end

    // R6: the phases must never overlap
    always @(posedge phi1) begin
        phase_excl_chk: assert (!phi2);
    end

    // R5
    clear_chk: assert property (@(posedge phi1) disable iff (!armed_q)
        clr |=> (count == '0));

    // R3
    wrap_chk: assert property (@(posedge phi1) disable iff (!armed_q)
        (!clr && ce && count == TOP_CODE) |=> (count == '0));

    // R2
    step_chk: assert property (@(posedge phi1) disable iff (!armed_q)
        (!clr && ce && count < TOP_CODE) |=> (count == CNT_W'($past(count) + 1'b1)));

    // R4
    hold_chk: assert property (@(posedge phi1) disable iff (!armed_q)
        (!clr && !ce) |=> $stable(count));

    // R7
    range_chk: assert property (@(posedge phi1) disable iff (!armed_q)
        count <= TOP_CODE);
endmodule

bind mod5_phase_counter mod5_phase_chk #(.CNT_W(CNT_W), .TOP_VAL(TOP_VAL)) u_chk (
    .phi1  (phi1),
    .phi2  (phi2),
    .ce    (ce),
    .clr   (clr),
    .count (count)
);

// File: tb/mod5_phase_counter_tb.sv
module mod5_phase_counter_tb;
    localparam int PHASE_NS = 10;
    localparam int DEAD_NS  = 5;
    localparam int PERIOD   = 2 * (PHASE_NS + DEAD_NS);
    localparam int WDOG_CYC = 2000;

    logic       phi1 = 1'b0;
    logic       phi2 = 1'b0;
    logic       ce   = 1'b0;
    logic       clr  = 1'b0;
    logic [2:0] count;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    int  model = 0;

    mod5_phase_counter u_dut (
        .phi1  (phi1),
        .phi2  (phi2),
        .ce    (ce),
        .clr   (clr),
        .count (count)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one phase cycle with inputs set while both phases are low
    task automatic step(input logic c, input logic k);
        int prev;
        int nxt;
        prev = model;
        ce  = c;
        clr = k;
        #DEAD_NS;
        phi1 = 1'b1;
        #(PHASE_NS / 2);
        check("R6", int'(count), prev);        // stable mid phi1
        #(PHASE_NS / 2);
        phi1 = 1'b0;
        #DEAD_NS;
        phi2 = 1'b1;
        #PHASE_NS;
        phi2 = 1'b0;
        if (k)           nxt = 0;
        else if (!c)     nxt = prev;
        else if (prev == 4) nxt = 0;
        else             nxt = prev + 1;
        model = nxt;
        #1;
        if (k)                 check("R5", int'(count), nxt);
        else if (!c)           check("R4", int'(count), nxt);
        else if (prev == 4)    check("R3", int'(count), nxt);
        else begin
            check("R2", int'(count), nxt);
            check("R1", int'(count[0]), (prev & 1) ^ 1);
        end
        check("R7", int'(count <= 3'd4), 1);
    endtask

    initial begin
        // reset state through external clear
        step(1'b0, 1'b1);
        check("R5", int'(count), 0);

        // enabled sweep across more than two laps
        for (int n = 0; n < 12; n++) step(1'b1, 1'b0);

        // hold at every value
        for (int v = 0; v < 5; v++) begin
            step(1'b0, 1'b1);
            for (int s = 0; s < v; s++) step(1'b1, 1'b0);
            for (int h = 0; h < 3; h++) step(1'b0, 1'b0);
        end

        // clear from every value, with enable high and low
        for (int e = 0; e < 2; e++) begin
            for (int v = 0; v < 5; v++) begin
                step(1'b0, 1'b1);
                for (int s = 0; s < v; s++) step(1'b1, 1'b0);
                step(e[0], 1'b1);
                check("R5", int'(count), 0);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(WDOG_CYC * PERIOD);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule